// File: doc/BRIEF.md
# Generation-Bit Completion Ring Writer

This block sits on the device side of a completion ring in host memory. It posts one descriptor per completion request. Each request carries a 16-bit tag that the host handed out earlier, a kind flag and an end-of-packet flag. The tag is a transmit completion tag or a receive buffer id, and the kind flag says which. Every ring entry is two 32-bit words. The word holding the generation bit is always written second, so a host that polls that bit never sees a half-written entry as new.

The writer keeps a write index into the ring and a generation value. After reset the index is zero and the generation value written is 1; the host fills every entry with 0 beforehand. When the index wraps from the last entry back to zero, the generation value inverts. Then entries left over from the previous lap read as stale. There is no consumer pointer. Upstream logic must keep the number of outstanding completions within the ring depth. A received packet that spans several buffers is posted as consecutive entries, and only the last one is flagged end-of-packet.

Requests arrive on a valid/ready stream. A request is taken on a cycle where `in_valid` and `in_ready` are both high, and the payload must be held steady while `in_valid` waits. Words leave on a valid/ready memory write port. While `wr_ready` is low, the pending word is held unchanged and `in_ready` stays low.

Top module: `cq_gen_writer`

## Requirements
- R1: After reset, `in_ready` is 1, `wr_valid` is 0 and `notify` is 0. The first entry goes to index 0 with generation value 1.
- R2: Each accepted request produces exactly two accepted writes, in order. The low word goes to byte offset index*8 and the high word to index*8+4.
- R3: The low word holds the tag in bits 15:0 and the kind flag in bit 16 (0 = transmit, 1 = receive). All other bits are zero.
- R4: The high word holds the end-of-packet flag in bit 0 and the generation value in bit 31. All other bits are zero.
- R5: The generation value is 1 on the first lap through the ring and inverts each time the index wraps to zero.
- R6: The index advances by one after each completed entry and wraps from 2^IDX_W-1 to 0.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged on the next cycle.
- R8: `in_ready` is high only when no entry is pending, or when the high word is being accepted in that cycle. No write is presented without an accepted request, and the payload pins are ignored while `in_valid` is low.
- R9: `notify` pulses high for exactly one cycle, in the cycle after each high word is accepted.
- R10: Consecutive requests fill consecutive entries, with no gaps. Each entry's end-of-packet bit follows its own request, so a multi-entry packet is closed only by its last entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Completion request valid |
| in_ready | output | 1 | Writer can accept a request |
| in_tag | input | 16 | Completion tag or buffer id |
| in_is_rx | input | 1 | 1 = receive entry, 0 = transmit entry |
| in_eop | input | 1 | Last entry of a packet |
| wr_valid | output | 1 | Memory write word valid |
| wr_ready | input | 1 | Memory accepts the word |
| wr_addr | output | IDX_W+3 | Byte offset of the word within the ring |
| wr_data | output | 32 | Word to write (little-endian byte order in memory) |
| notify | output | 1 | One-cycle pulse after each completed entry |

## Verification
The hardest situation to reach is a ring wrap in which the high word of the last entry is stalled, while a new request is already waiting. The writer must then hold the old generation value on the stalled word and use the inverted value only for the entry that follows. The stimulus runs well over four laps of the default 16-entry ring. It mixes a phase with `wr_ready` always high and back-to-back requests against a phase with random `wr_ready` stalls and random request gaps. As a result, wraps occur both with overlapped acceptance and under back-pressure. Random payload values are driven while `in_valid` is low to show that they are ignored.

// File: rtl/cq_gen_writer_pkg.sv
package cq_gen_writer_pkg;
  localparam int WORD_W   = 32;
  localparam int TAG_W    = 16;
  localparam int KIND_BIT = 16;
  localparam int EOP_BIT  = 0;
  localparam int GEN_BIT  = 31;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } seq_st_t;
endpackage

// File: rtl/cq_ring_pos.sv
module cq_ring_pos #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             gen
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      gen <= 1'b1;
    end else if (advance) begin
      idx <= idx + 1'b1;
      if (idx == LAST_IDX) gen <= ~gen;
    end
  end

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (idx == IDX_W'($past(idx) + 1'b1)));
  // R5
  gen_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && idx == LAST_IDX) |=> (gen != $past(gen)));
  // R5
  gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(idx) && $stable(gen)));
endmodule

// File: rtl/cq_entry_fmt.sv
module cq_entry_fmt
  import cq_gen_writer_pkg::*;
(
  input  logic              word_sel,
  input  logic [TAG_W-1:0]  tag,
  input  logic              is_rx,
  input  logic              eop,
  input  logic              gen,
  output logic [WORD_W-1:0] data
);
  always_comb begin
    data = '0;
    if (!word_sel) begin
      data[TAG_W-1:0] = tag;
      data[KIND_BIT]  = is_rx;
    end else begin
      data[EOP_BIT] = eop;
      data[GEN_BIT] = gen;
    end
  end

  // R4
  hi_word_clean_chk: assert final (!word_sel || (data[30:1] == '0));
endmodule

// File: rtl/cq_word_seq.sv
module cq_word_seq
  import cq_gen_writer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_is_rx,
  input  logic             in_eop,
  input  logic             wr_ready,
  output logic             wr_valid,
  output logic             word_sel,
  output logic [TAG_W-1:0] cap_tag,
  output logic             cap_rx,
  output logic             cap_eop,
  output logic             advance,
  output logic             notify
);
  seq_st_t st;
  logic lo_go, hi_go, take;

  assign lo_go    = (st == ST_LO) && wr_ready;
  assign hi_go    = (st == ST_HI) && wr_ready;
  assign in_ready = (st == ST_IDLE) || hi_go;
  assign take     = in_valid && in_ready;
  assign wr_valid = (st != ST_IDLE);
  assign word_sel = (st == ST_HI);
  assign advance  = hi_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      notify  <= 1'b0;
      cap_tag <= '0;
      cap_rx  <= 1'b0;
      cap_eop <= 1'b0;
    end else begin
      notify <= hi_go;
      if (take) begin
        cap_tag <= in_tag;
        cap_rx  <= in_is_rx;
        cap_eop <= in_eop;
      end
      unique case (st)
        ST_IDLE: if (take) st <= ST_LO;
        ST_LO:   if (lo_go) st <= ST_HI;
        ST_HI:   if (hi_go) st <= take ? ST_LO : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (wr_valid && !word_sel));
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(word_sel) && $stable(cap_tag)));
  // R9
  notify_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && word_sel && wr_ready) |=> notify);
  // R9
  notify_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify |=> !notify);
endmodule

// File: rtl/cq_gen_writer.sv
module cq_gen_writer
  import cq_gen_writer_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_is_rx,
  input  logic              in_eop,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [IDX_W+2:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              notify
);
  logic             word_sel, advance, gen, cap_rx, cap_eop;
  logic [TAG_W-1:0] cap_tag;
  logic [IDX_W-1:0] idx;

  cq_word_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_is_rx(in_is_rx), .in_eop(in_eop),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .word_sel(word_sel),
    .cap_tag(cap_tag), .cap_rx(cap_rx), .cap_eop(cap_eop),
    .advance(advance), .notify(notify)
  );

  cq_ring_pos #(.IDX_W(IDX_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .advance(advance), .idx(idx), .gen(gen)
  );

  cq_entry_fmt u_fmt (
    .word_sel(word_sel), .tag(cap_tag), .is_rx(cap_rx),
    .eop(cap_eop), .gen(gen), .data(wr_data)
  );

  assign wr_addr = {idx, word_sel, 2'b00};

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ($stable(wr_addr) && $stable(wr_data)));
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && in_ready && !notify));
endmodule

// File: tb/cq_gen_writer_test.sv
module cq_gen_writer_test;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_rx = 1'b0, in_eop = 1'b0, wr_ready = 1'b0;
  logic [15:0] in_tag = '0;
  logic in_ready, wr_valid, notify;
  logic [IDX_W+2:0] wr_addr;
  logic [31:0] wr_data;

  always #2 clk = ~clk;

  cq_gen_writer #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_is_rx(in_is_rx), .in_eop(in_eop),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .notify(notify)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_addr[$];
  logic [31:0] exp_data[$];
  int m_idx = 0;
  int m_gen = 1;
  bit notify_due = 0;
  bit stalled = 0;
  int p_addr;
  logic [31:0] p_data;
  bit holding = 0;
  int sent = 0;
  int seq_n = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one clock: drive at negedge, compare against the model shortly after
  task automatic cycle(input int target, input int in_pct, input int rdy_pct);
    @(negedge clk);
    if (!holding && sent < target && ($urandom % 100) < in_pct) begin
      holding  = 1;
      in_tag   = 16'($urandom);
      in_is_rx = 1'($urandom);
      in_eop   = (seq_n % 3 == 2);
      seq_n++;
    end else if (!holding) begin
      in_tag   = 16'($urandom);  // R8: garbage while not valid
      in_is_rx = 1'($urandom);
      in_eop   = 1'($urandom);
    end
    in_valid = holding;
    wr_ready = (($urandom % 100) < rdy_pct);
    #1;
    chk(wr_valid == (exp_addr.size() != 0), "R8 wr_valid", wr_valid, exp_addr.size() != 0);
    chk(in_ready == (exp_addr.size() == 0 || (exp_addr.size() == 1 && wr_ready)),
        "R8 in_ready", in_ready, exp_addr.size() == 0 || (exp_addr.size() == 1 && wr_ready));
    chk(notify == notify_due, "R9 notify", notify, notify_due);
    notify_due = 0;
    if (stalled)
      chk(wr_valid && int'(wr_addr) == p_addr && wr_data == p_data, "R7 hold",
          wr_data, p_data);
    if (wr_valid && wr_ready && exp_addr.size() != 0) begin
      int ea;
      logic [31:0] ed;
      ea = exp_addr.pop_front();
      ed = exp_data.pop_front();
      chk(int'(wr_addr) == ea, "R2/R6 addr", wr_addr, ea);
      if (ea % 8 == 0) chk(wr_data == ed, "R3 low word", wr_data, ed);
      else begin
        chk(wr_data == ed, "R4/R5/R10 high word", wr_data, ed);
        notify_due = 1;
      end
    end
    stalled = wr_valid && !wr_ready;
    p_addr = int'(wr_addr);
    p_data = wr_data;
    if (in_valid && in_ready) begin
      exp_addr.push_back(m_idx * 8);
      exp_data.push_back({15'b0, in_is_rx, in_tag});
      exp_addr.push_back(m_idx * 8 + 4);
      exp_data.push_back({m_gen[0], 30'b0, in_eop});
      if (m_idx == DEPTH - 1) begin
        m_idx = 0;
        m_gen ^= 1;
      end else m_idx++;
      holding = 0;
      sent++;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    chk(notify == 1'b0, "R1 notify", notify, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1 && wr_valid == 1'b0, "R1 after release", wr_valid, 0);
    // idle: payload toggles with in_valid low, nothing may be written (R8)
    for (int i = 0; i < 10; i++) cycle(0, 0, 100);
    // back-to-back, no back-pressure: overlapped acceptance and wraps (R5, R6, R10)
    for (int i = 0; i < 200 && sent < 40; i++) cycle(40, 100, 100);
    // random stalls and gaps (R7)
    for (int i = 0; i < 3000 && sent < 120; i++) cycle(120, 60, 55);
    // drain
    for (int i = 0; i < 20; i++) cycle(sent, 0, 100);
    chk(exp_addr.size() == 0, "R2 all words written", exp_addr.size(), 0);
    chk(sent == 120, "R10 all requests taken", sent, 120);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=complete");
      finish_run();
    end
  end
endmodule